// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block sits on the host side of a linear photodiode array that has one analog output. It drives the array's start line and clock line. For every pixel it raises a strobe towards an external ADC and puts the pixel number next to that strobe. All sensor timing is counted in system-clock cycles. The block sets the length of each clock phase, the number of clocks in a frame, the quiet gap that lets the last pixel's charge transfer finish, and the start-to-start interval that sets how long the array integrates.

A frame starts in one of three ways. A one-cycle request starts a single frame. A free-run level starts frames back to back at the programmed interval. After reset, a flush frame starts by itself. The clock half-period and the requested integration time are sampled when each frame starts. Both are clamped into the legal range. A request that is too long raises an error flag for that frame. The data read out during a frame belongs to the integration period that ended at that frame's start. The flush frame therefore carries only stale charge, and the block suppresses its strobes.

Top module: `linescan_seq`

## Requirements
- R1: While reset is held, sen_clk, sen_si, adc_strobe, frame_done and err are all low.
- R2: After reset is released, one flush frame starts by itself with the full clock count. It produces no adc_strobe and no frame_done.
- R3: In each frame, sen_si rises while sen_clk is low. The first rising edge of sen_clk follows one half-period later. sen_si falls in the same cycle as the first falling edge of sen_clk. The frame has exactly PIX+1 rising edges, and sen_clk then stays low.
- R4: Each high phase and each low phase of sen_clk lasts H system cycles. H is div_half clamped to the range [MIN_HALF, MAX_HALF] and sampled at frame start.
- R5: In clock periods 1 to PIX, adc_strobe is high for one cycle: the last system cycle of the period, while sen_clk is low. pix_idx carries the value k-1 for period k, so the index rises from 0 to PIX-1.
- R6: frame_done is high for exactly one cycle, the cycle after the strobe whose pix_idx is PIX-1.
- R7: In free run, the interval from one sen_si rise to the next is int_req + 2*RC*H cycles, provided that value lies within the legal range.
- R8: A requested interval below (2*PIX+2)*H + GAP is raised to that value, and err stays low.
- R9: A requested interval above MAX_INTERVAL is cut to MAX_INTERVAL, and err is high for that frame. err is re-evaluated at every frame start.
- R10: A frame_req that arrives while the block is idle and the interval has elapsed makes sen_si rise on the next cycle. A frame_req that arrives earlier is held, and sen_si then rises at the earliest legal start.
- R11: With free_run low and no request pending, no new frame starts after the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_req | input | 1 | One-cycle request for a single frame |
| free_run | input | 1 | Level; start frames back to back at the programmed interval |
| div_half | input | DIV_W | Requested sensor-clock half-period in system cycles |
| int_req | input | IW | Requested integration time in system cycles |
| sen_clk | output | 1 | Sensor clock |
| sen_si | output | 1 | Sensor start pulse |
| adc_strobe | output | 1 | One-cycle sample strobe for the external ADC |
| pix_idx | output | IDX_W | Pixel number belonging to the strobe |
| frame_done | output | 1 | One-cycle pulse after the last pixel strobe |
| err | output | 1 | The current frame's interval was cut to the ceiling |

## Verification
The bench runs the core frame sequence in four situations, and each one exposes a different class of fault:
- A single requested frame at a mid-range half-period pins down the absolute cycle of every start, edge, strobe and done pulse. This catches off-by-one errors in the phase counters.
- Half-periods of zero and of above the maximum show whether the clamp acts on both phases.
- Free run with an in-range request, a too-short request and a too-long request separates the three branches of the interval clamp and the err behaviour.
- A request placed in the middle of a frame, followed by a long quiet stretch, shows whether requests are held until a legal start and whether the block then stays idle.

// File: rtl/linescan_pkg.sv
// Shared types for the linear sensor readout sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package linescan_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_RUN
    } phase_t;
endpackage

// File: rtl/lsq_timing_calc.sv
// Combinational clamp of the per-frame timing request.
// Produces the legal clock half-period and the start-to-start interval.
// Assumes: MIN_HALF >= 2, GAP >= 1, MAX_INTERVAL fits in IW bits.
module lsq_timing_calc #(
    parameter int PIX          = 128,
    parameter int RC           = 18,
    parameter int GAP          = 1000,
    parameter int MIN_HALF     = 4,
    parameter int MAX_HALF     = 5000,
    parameter int MAX_INTERVAL = 5000000,
    parameter int DIV_W        = 13,
    parameter int IW           = 23
) (
    input  logic [DIV_W-1:0] div_half,
    input  logic [IW-1:0]    int_req,
    output logic [DIV_W-1:0] half_c,
    output logic [IW-1:0]    interval_c,
    output logic             over_c
);
    localparam int WW = IW + DIV_W + 8;

    logic [WW-1:0] span;
    logic [WW-1:0] want;
    logic [WW-1:0] floor_v;
    logic [WW-1:0] pick;

    // Clamp the half-period, then derive and clamp the start-to-start interval.
    always_comb begin
        if (div_half < DIV_W'(MIN_HALF)) begin
            half_c = DIV_W'(MIN_HALF);
        end else if (div_half > DIV_W'(MAX_HALF)) begin
            half_c = DIV_W'(MAX_HALF);
        end else begin
            half_c = div_half;
        end
        span    = WW'(half_c);
        want    = WW'(int_req) + WW'(2 * RC) * span;
        floor_v = WW'(2 * PIX + 2) * span + WW'(GAP);
        pick    = (want < floor_v) ? floor_v : want;
        over_c  = (pick > WW'(MAX_INTERVAL));
        interval_c = over_c ? IW'(MAX_INTERVAL) : pick[IW-1:0];
    end
endmodule

// File: rtl/lsq_frame_ctrl.sv
// Frame scheduler: decides when a start is legal and wanted, latches the
// per-frame timing, holds early requests and suppresses the flush frame.
// Assumes: the phase generator goes idle before the interval has elapsed,
// which the interval floor guarantees.
module lsq_frame_ctrl #(
    parameter int PIX          = 128,
    parameter int GAP          = 1000,
    parameter int MIN_HALF     = 4,
    parameter int MAX_INTERVAL = 5000000,
    parameter int DIV_W        = 13,
    parameter int IW           = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_req,
    input  logic             free_run,
    input  logic             seq_idle,
    input  logic [DIV_W-1:0] half_c,
    input  logic [IW-1:0]    interval_c,
    input  logic             over_c,
    output logic             start,
    output logic [DIV_W-1:0] half_q,
    output logic             report,
    output logic             err
);
    localparam int FW = IW + DIV_W + 8;

    logic [IW-1:0] ic;
    logic [IW-1:0] t_q;
    logic          armed;
    logic          counting;
    logic          flush;
    logic          pending;
    logic          elapsed;

    // Start when the interval is over, the sequencer is idle and a frame is wanted.
    always_comb begin
        elapsed = armed | (counting && (ic == t_q - IW'(1)));
        start   = elapsed && seq_idle && (flush | free_run | frame_req | pending);
    end

    // Interval counting, per-frame latching, request holding and flush tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ic       <= '0;
            t_q      <= '0;
            armed    <= 1'b1;
            counting <= 1'b0;
            flush    <= 1'b1;
            pending  <= 1'b0;
            report   <= 1'b0;
            err      <= 1'b0;
            half_q   <= DIV_W'(MIN_HALF);
        end else begin
            pending <= (pending | frame_req) & ~start;
            if (start) begin
                ic       <= '0;
                counting <= 1'b1;
                armed    <= 1'b0;
                t_q      <= interval_c;
                half_q   <= half_c;
                err      <= over_c;
                report   <= ~flush;
                flush    <= 1'b0;
            end else if (counting) begin
                ic <= ic + IW'(1);
                if (ic == t_q - IW'(1)) begin
                    armed    <= 1'b1;
                    counting <= 1'b0;
                end
            end
        end
    end

    // R9
    err_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (t_q == IW'(MAX_INTERVAL)));

    // R8
    floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !err) |-> (FW'(t_q) >= FW'(2 * PIX + 2) * FW'(half_q) + FW'(GAP)));
endmodule

// File: rtl/lsq_phase_gen.sv
// Sensor clock, start pulse and ADC strobe generator for one frame.
// Frame: a lead phase of H cycles with start high and clock low, then PIX+1
// clock periods of 2H cycles. The clock rests low at the end.
// Assumes: half >= 2, held stable for the whole frame.
module lsq_phase_gen
    import linescan_pkg::*;
#(
    parameter int PIX   = 128,
    parameter int DIV_W = 13,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             report,
    input  logic [DIV_W-1:0] half,
    output logic             seq_idle,
    output logic             sen_clk,
    output logic             sen_si,
    output logic             adc_strobe,
    output logic [IDX_W-1:0] pix_idx,
    output logic             frame_done
);
    localparam int HW = DIV_W + 1;
    localparam int EW = $clog2(PIX + 2);

    phase_t        st;
    logic [HW-1:0] hc;
    logic [EW-1:0] ec;
    logic [HW-1:0] h_end;
    logic [HW-1:0] p_end;
    logic [HW-1:0] p_late;

    // Phase boundaries within one clock period.
    always_comb begin
        h_end    = HW'(half) - HW'(1);
        p_end    = (HW'(half) << 1) - HW'(1);
        p_late   = (HW'(half) << 1) - HW'(2);
        seq_idle = (st == PH_IDLE);
    end

    // Walk lead, clock periods and strobes for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= PH_IDLE;
            hc         <= '0;
            ec         <= '0;
            sen_clk    <= 1'b0;
            sen_si     <= 1'b0;
            adc_strobe <= 1'b0;
            pix_idx    <= '0;
            frame_done <= 1'b0;
        end else begin
            adc_strobe <= 1'b0;
            frame_done <= adc_strobe && (pix_idx == IDX_W'(PIX - 1));
            case (st)
                PH_IDLE: begin
                    if (start) begin
                        st     <= PH_LEAD;
                        sen_si <= 1'b1;
                        hc     <= '0;
                    end
                end
                PH_LEAD: begin
                    if (hc == h_end) begin
                        sen_clk <= 1'b1;
                        st      <= PH_RUN;
                        hc      <= '0;
                        ec      <= EW'(1);
                    end else begin
                        hc <= hc + HW'(1);
                    end
                end
                PH_RUN: begin
                    if (hc == h_end) begin
                        sen_clk <= 1'b0;
                        if (ec == EW'(1)) sen_si <= 1'b0;
                        if (ec == EW'(PIX + 1)) st <= PH_IDLE;
                        hc <= hc + HW'(1);
                    end else if (hc == p_end) begin
                        sen_clk <= 1'b1;
                        ec      <= ec + EW'(1);
                        hc      <= '0;
                    end else begin
                        hc <= hc + HW'(1);
                    end
                    if ((hc == p_late) && (ec <= EW'(PIX)) && report) begin
                        adc_strobe <= 1'b1;
                        pix_idx    <= IDX_W'(ec - EW'(1));
                    end
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    // R3
    si_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sen_si) |-> !sen_clk);

    // R3
    si_fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sen_si) |-> $fell(sen_clk));

    // R5
    strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe |-> !sen_clk);

    // R6
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(adc_strobe));
endmodule

// File: rtl/linescan_seq.sv
// Host-side readout sequencer for a linear photodiode array.
// Connects the timing clamp, the frame scheduler and the phase generator.
// Assumes: all timing parameters are in system-clock cycles.
module linescan_seq #(
    parameter int PIX          = 128,
    parameter int RC           = 18,
    parameter int GAP          = 1000,
    parameter int MIN_HALF     = 4,
    parameter int MAX_HALF     = 5000,
    parameter int MAX_INTERVAL = 5000000,
    localparam int DIV_W       = $clog2(MAX_HALF + 1),
    localparam int IW          = $clog2(MAX_INTERVAL + 1),
    localparam int IDX_W       = $clog2(PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_req,
    input  logic             free_run,
    input  logic [DIV_W-1:0] div_half,
    input  logic [IW-1:0]    int_req,
    output logic             sen_clk,
    output logic             sen_si,
    output logic             adc_strobe,
    output logic [IDX_W-1:0] pix_idx,
    output logic             frame_done,
    output logic             err
);
    logic [DIV_W-1:0] half_c;
    logic [DIV_W-1:0] half_q;
    logic [IW-1:0]    interval_c;
    logic             over_c;
    logic             start;
    logic             report;
    logic             seq_idle;

    lsq_timing_calc #(
        .PIX(PIX), .RC(RC), .GAP(GAP), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF),
        .MAX_INTERVAL(MAX_INTERVAL), .DIV_W(DIV_W), .IW(IW)
    ) calc_i (
        .div_half(div_half), .int_req(int_req),
        .half_c(half_c), .interval_c(interval_c), .over_c(over_c)
    );

    lsq_frame_ctrl #(
        .PIX(PIX), .GAP(GAP), .MIN_HALF(MIN_HALF), .MAX_INTERVAL(MAX_INTERVAL),
        .DIV_W(DIV_W), .IW(IW)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .free_run(free_run),
        .seq_idle(seq_idle), .half_c(half_c), .interval_c(interval_c),
        .over_c(over_c), .start(start), .half_q(half_q), .report(report), .err(err)
    );

    lsq_phase_gen #(
        .PIX(PIX), .DIV_W(DIV_W), .IDX_W(IDX_W)
    ) phase_i (
        .clk(clk), .rst_n(rst_n), .start(start), .report(report), .half(half_q),
        .seq_idle(seq_idle), .sen_clk(sen_clk), .sen_si(sen_si),
        .adc_strobe(adc_strobe), .pix_idx(pix_idx), .frame_done(frame_done)
    );
endmodule

// File: tb/linescan_seq_tb_top.sv
module linescan_seq_tb_top;
    localparam int PIX = 8, RC = 3, GAP = 5, MINH = 2, MAXH = 6, MAXI = 400;
    localparam int DIV_W = $clog2(MAXH + 1);
    localparam int IW = $clog2(MAXI + 1);
    localparam int IDX_W = $clog2(PIX);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_req = 1'b0;
    logic free_run = 1'b0;
    logic [DIV_W-1:0] div_half = DIV_W'(3);
    logic [IW-1:0] int_req = IW'(50);
    logic sen_clk, sen_si, adc_strobe, frame_done, err;
    logic [IDX_W-1:0] pix_idx;

    int total = 0, bad = 0, cyc = 0;
    int rises = 0, last_rise = 0, prev_rise = 0, si_fall = 0;
    int edges = 0, first_edge = 0, hi_start = 0, lo_start = 0, hi_len = 0, lo_len = 0;
    int strobes = 0, first_strobe = 0, dones = 0, done_t = 0;
    logic p_si = 1'b0, p_clk = 1'b0, p_stb = 1'b0;
    logic [IDX_W-1:0] p_idx = '0;
    bit finished = 1'b0;

    linescan_seq #(.PIX(PIX), .RC(RC), .GAP(GAP), .MIN_HALF(MINH), .MAX_HALF(MAXH),
                   .MAX_INTERVAL(MAXI)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .free_run(free_run),
        .div_half(div_half), .int_req(int_req), .sen_clk(sen_clk), .sen_si(sen_si),
        .adc_strobe(adc_strobe), .pix_idx(pix_idx), .frame_done(frame_done), .err(err));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: timestamps of every sensor event, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sen_si && !p_si) begin
                rises++; prev_rise = last_rise; last_rise = cyc; edges = 0; strobes = 0;
            end
            if (!sen_si && p_si) begin
                si_fall = cyc;
                chk(p_clk && !sen_clk, "R3 si falls with clock", int'(sen_clk), 0);
            end
            if (sen_clk && !p_clk) begin
                if (edges == 0) first_edge = cyc;
                else lo_len = cyc - lo_start;
                edges++; hi_start = cyc;
            end
            if (!sen_clk && p_clk) begin
                hi_len = cyc - hi_start; lo_start = cyc;
            end
            if (adc_strobe) begin
                if (strobes == 0) first_strobe = cyc;
                chk(int'(pix_idx) == strobes && !sen_clk, "R5 strobe index", int'(pix_idx), strobes);
                strobes++;
            end
            if (frame_done) begin
                done_t = cyc; dones++;
                chk(p_stb && int'(p_idx) == PIX - 1, "R6 done follows last strobe", int'(p_idx), PIX - 1);
            end
        end
        p_si = sen_si; p_clk = sen_clk; p_stb = adc_strobe; p_idx = pix_idx;
    end

    task automatic wait_rise(input int target);
        int to = 0;
        while (rises < target && to < 2000) begin
            @(posedge clk); to++;
        end
        chk(rises >= target, "R10 start seen", rises, target);
    endtask

    task automatic pulse_req(output int t);
        @(negedge clk); frame_req = 1'b1; t = cyc;
        @(negedge clk); frame_req = 1'b0;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(!sen_clk && !sen_si && !adc_strobe && !frame_done && !err, "R1 reset outputs low",
            int'({sen_clk, sen_si, adc_strobe, frame_done, err}), 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_flush();
        wait_rise(1);
        repeat (80) @(posedge clk);
        chk(edges == PIX + 1, "R3 flush edge count", edges, PIX + 1);
        chk(strobes == 0 && dones == 0, "R2 flush frame silent", strobes + dones, 0);
        chk(rises == 1, "R11 idle after flush", rises, 1);
        chk(!sen_clk, "R3 clock rests low", int'(sen_clk), 0);
    endtask

    task automatic t_single();
        int rt;
        pulse_req(rt);
        wait_rise(2);
        repeat (70) @(posedge clk);
        chk(last_rise == rt + 1, "R10 idle request starts next cycle", last_rise, rt + 1);
        chk(first_edge == last_rise + 3, "R3 lead phase", first_edge - last_rise, 3);
        chk(si_fall == first_edge + 3, "R3 si drop time", si_fall - first_edge, 3);
        chk(hi_len == 3 && lo_len == 3, "R4 phases at H=3", hi_len * 10 + lo_len, 33);
        chk(edges == PIX + 1, "R3 edge count", edges, PIX + 1);
        chk(strobes == PIX, "R5 strobe count", strobes, PIX);
        chk(first_strobe == last_rise + 8, "R5 first strobe cycle", first_strobe - last_rise, 8);
        chk(dones == 1 && done_t == last_rise + 51, "R6 done cycle", done_t - last_rise, 51);
        chk(!err, "R9 err low in range", int'(err), 0);
    endtask

    task automatic t_div_clamp();
        int rt;
        div_half = '0;
        pulse_req(rt);
        wait_rise(3);
        repeat (70) @(posedge clk);
        chk(hi_len == 2 && lo_len == 2, "R4 clamp up to MIN_HALF", hi_len * 10 + lo_len, 22);
        chk(first_edge - last_rise == 2, "R4 lead at MIN_HALF", first_edge - last_rise, 2);
        div_half = DIV_W'(7);
        pulse_req(rt);
        wait_rise(4);
        repeat (120) @(posedge clk);
        chk(hi_len == 6 && lo_len == 6, "R4 clamp down to MAX_HALF", hi_len * 10 + lo_len, 66);
        chk(edges == PIX + 1, "R3 edge count at MAX_HALF", edges, PIX + 1);
    endtask

    task automatic t_interval();
        int r;
        div_half = DIV_W'(2); int_req = IW'(50);
        @(negedge clk); free_run = 1'b1;
        r = rises; wait_rise(r + 1); wait_rise(r + 2);
        chk(last_rise - prev_rise == 62, "R7 free-run interval", last_rise - prev_rise, 62);
        chk(!err, "R7 err low", int'(err), 0);
        int_req = IW'(10);
        r = rises; wait_rise(r + 1); wait_rise(r + 2);
        chk(last_rise - prev_rise == 41, "R8 floor interval", last_rise - prev_rise, 41);
        chk(!err, "R8 err low when raised", int'(err), 0);
        int_req = IW'(500);
        r = rises; wait_rise(r + 1);
        @(negedge clk);
        chk(err, "R9 err high when cut", int'(err), 1);
        wait_rise(r + 2);
        chk(last_rise - prev_rise == MAXI, "R9 ceiling interval", last_rise - prev_rise, MAXI);
        int_req = IW'(50);
        r = rises; wait_rise(r + 1);
        @(negedge clk);
        chk(!err, "R9 err clears at next start", int'(err), 0);
        free_run = 1'b0;
        repeat (100) @(posedge clk);
    endtask

    task automatic t_pending();
        int rt, r;
        repeat (100) @(posedge clk);
        r = rises;
        pulse_req(rt);
        wait_rise(r + 1);
        repeat (10) @(posedge clk);
        pulse_req(rt);
        wait_rise(r + 2);
        chk(last_rise - prev_rise == 62, "R10 held request at earliest start", last_rise - prev_rise, 62);
        repeat (200) @(posedge clk);
        chk(rises == r + 2, "R11 no extra frame", rises, r + 2);
        chk(!sen_clk && !sen_si, "R11 lines idle", int'({sen_clk, sen_si}), 0);
    endtask

    initial begin
        t_reset();
        t_flush();
        t_single();
        t_div_clamp();
        t_interval();
        t_pending();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule